// File: doc/BRIEF.md
# Frame and Line Valid Timing Generator

This block produces the parallel-output raster timing of an image sensor. It advances one pixel slot for each cycle in which the pixel-clock enable is high. It drives a frame-valid level, a line-valid level, a per-pixel strobe, and the row and column index of the active pixel, which the downstream data path uses to address or tag its samples.

Four programmed values shape each frame:
- the active width A, in slots;
- the line length L, in slots;
- the number of active rows N;
- the frame length F, in lines.

The frame lasts exactly L*F slots. Frame-valid opens a fixed guard of G = 6 slots before the first line-valid of the frame. It closes G slots after the last line-valid of the frame. As a result, frame-valid stays high for N*L − (L−A) + 2G slots, and vertical blanking takes the rest of the frame.

The programmed values are captured only at a frame boundary, so a frame is never built from two settings. A setting that cannot form a valid frame is refused. The block keeps the previous setting and raises an error flag.

Top module: `frame_line_timer`

## Requirements
- R1: While reset is active, and after reset until the first slot enable, frame_valid, line_valid, pix_valid, row_idx, col_idx and cfg_err are all 0.
- R2: Slot t of a frame, with t counted from 0, maps to a raster position u = t − 6. For u ≥ 0, the row is u / L and the column is u mod L. line_valid is 1 exactly when u ≥ 0, the row is below N and the column is below A. A frame contains L*F slots in total.
- R3: frame_valid rises in slot 0 of each frame, which is 6 slots before the first line_valid of that frame. line_valid is never 1 while frame_valid is 0.
- R4: frame_valid stays high for 6 slots after the last line_valid slot of the frame and then falls.
- R5: frame_valid is high for slots t < 12 + (N−1)*L + A of a frame and low for the remaining slots, up to L*F.
- R6: pix_valid equals line_valid AND pix_en, which gives one pixel strobe per enabled active slot.
- R7: During line_valid, row_idx and col_idx give the active row and column. Outside line_valid, both are 0.
- R8: A cycle with pix_en low does not advance the slot. All outputs other than pix_valid hold their values.
- R9: act_width, line_len, act_rows and frame_lines are sampled only on the enable that begins a frame: the first enable after reset, or the enable that ends slot L*F−1. A change made in mid-frame takes effect from the next frame.
- R10: A setting is legal only when A ≥ 1, N ≥ 1, L ≥ A+1, L ≥ 12 and F ≥ N+1. At a frame start, an illegal setting keeps the previous values and sets cfg_err to 1. A legal setting clears cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable, one slot per high cycle |
| act_width | input | HW | Active slots per line (A) |
| line_len | input | HW | Slots per line (L) |
| act_rows | input | VW | Active rows per frame (N) |
| frame_lines | input | VW | Lines per frame (F) |
| frame_valid | output | 1 | Frame-valid level |
| line_valid | output | 1 | Line-valid level |
| pix_valid | output | 1 | Pixel strobe |
| row_idx | output | VW | Active row index, 0 outside active slots |
| col_idx | output | HW | Active column index, 0 outside active slots |
| cfg_err | output | 1 | Last sampled setting was illegal |

## Verification
The assertions check, on every clock:
- line-valid is contained within frame-valid;
- line-valid is low at each frame-valid edge;
- counters are frozen while the enable is low;
- the column counter stays within the line;
- the held setting is both legal and frozen between frame boundaries.

Only the bench's scenarios can show the exact slot positions of the edges. Its slot-based model covers guard lengths, frame period under irregular enables, deferred use of a mid-frame setting change, and the refusal and recovery around illegal settings.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic [1:0] {
    FLT_IDLE = 2'd0,
    FLT_LEAD = 2'd1,
    FLT_ACT  = 2'd2
  } flt_state_e;
endpackage

// File: rtl/flt_cfg_shadow.sv
module flt_cfg_shadow #(
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int GUARD = 6,
  parameter int DEF_A = 1832,
  parameter int DEF_L = 3694,
  parameter int DEF_N = 2748,
  parameter int DEF_F = 2891
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] a_i,
  input  logic [HW-1:0] l_i,
  input  logic [VW-1:0] n_i,
  input  logic [VW-1:0] f_i,
  output logic [HW-1:0] a_s,
  output logic [HW-1:0] l_s,
  output logic [VW-1:0] n_s,
  output logic [VW-1:0] f_s,
  output logic          err_o
);
  localparam logic [HW-1:0] MIN_LINE = HW'(2 * GUARD);

  logic [HW-1:0] a_q, a_d, l_q, l_d;
  logic [VW-1:0] n_q, n_d, f_q, f_d;
  logic          err_q, err_d, legal;

  always_comb begin
    legal = (a_i != '0) && (n_i != '0) && (l_i > a_i) &&
            (l_i >= MIN_LINE) && (f_i > n_i);
    a_d = a_q; l_d = l_q; n_d = n_q; f_d = f_q; err_d = err_q;
    if (load) begin
      if (legal) begin
        a_d = a_i; l_d = l_i; n_d = n_i; f_d = f_i;
        err_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= HW'(DEF_A);
      l_q   <= HW'(DEF_L);
      n_q   <= VW'(DEF_N);
      f_q   <= VW'(DEF_F);
      err_q <= 1'b0;
    end else begin
      a_q   <= a_d;
      l_q   <= l_d;
      n_q   <= n_d;
      f_q   <= f_d;
      err_q <= err_d;
    end
  end

  assign a_s   = a_q;
  assign l_s   = l_q;
  assign n_s   = n_q;
  assign f_s   = f_q;
  assign err_o = err_q;

  // R9: the held setting only moves at a frame boundary
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(a_q) && $stable(l_q) && $stable(n_q) && $stable(f_q)));

  // R10: an illegal request never reaches the held setting
  p_keep_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (l_q > a_q) && (f_q > n_q) && (a_q != '0) && (n_q != '0));
endmodule

// File: rtl/flt_raster.sv
module flt_raster
  import flt_pkg::*;
#(
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int GUARD = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] l_s,
  input  logic [VW-1:0] f_s,
  output flt_state_e    state_o,
  output logic [HW-1:0] hc_o,
  output logic [VW-1:0] vc_o,
  output logic          load_o
);
  localparam logic [HW-1:0] LEAD_LAST = HW'(GUARD - 1);
  localparam logic [HW-1:0] GUARD_H   = HW'(GUARD);

  flt_state_e    state_q, state_d;
  logic [HW-1:0] hc_q, hc_d, eol_pos;
  logic [VW-1:0] vc_q, vc_d;
  logic          last_line, at_eol;

  always_comb begin
    state_d   = state_q;
    hc_d      = hc_q;
    vc_d      = vc_q;
    load_o    = 1'b0;
    last_line = (vc_q == f_s - VW'(1));
    // the closing line is shortened by the lead so that a frame spans L*F slots
    eol_pos   = last_line ? (l_s - GUARD_H - HW'(1)) : (l_s - HW'(1));
    at_eol    = (hc_q == eol_pos);
    if (en) begin
      case (state_q)
        FLT_IDLE: begin
          state_d = FLT_LEAD; hc_d = '0; vc_d = '0; load_o = 1'b1;
        end
        FLT_LEAD: begin
          if (hc_q == LEAD_LAST) begin
            state_d = FLT_ACT; hc_d = '0; vc_d = '0;
          end else begin
            hc_d = hc_q + HW'(1);
          end
        end
        FLT_ACT: begin
          if (at_eol && last_line) begin
            state_d = FLT_LEAD; hc_d = '0; vc_d = '0; load_o = 1'b1;
          end else if (at_eol) begin
            hc_d = '0; vc_d = vc_q + VW'(1);
          end else begin
            hc_d = hc_q + HW'(1);
          end
        end
        default: state_d = FLT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FLT_IDLE;
      hc_q    <= '0;
      vc_q    <= '0;
    end else begin
      state_q <= state_d;
      hc_q    <= hc_d;
      vc_q    <= vc_d;
    end
  end

  assign state_o = state_q;
  assign hc_o    = hc_q;
  assign vc_o    = vc_q;

  // R8: no slot advance without the enable
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(hc_q) && $stable(vc_q) && $stable(state_q)));

  // R2: the column position never leaves the line
  p_col_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FLT_ACT) |-> (hc_q < l_s));
endmodule

// File: rtl/flt_guard.sv
module flt_guard
  import flt_pkg::*;
#(
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int GUARD = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  flt_state_e    state_i,
  input  logic [HW-1:0] hc_i,
  input  logic [VW-1:0] vc_i,
  input  logic [HW-1:0] a_s,
  input  logic [VW-1:0] n_s,
  output logic          lv_o,
  output logic          fv_o
);
  localparam int GW = $clog2(GUARD + 1);

  logic [GW-1:0] tr_q, tr_d;
  logic          in_act, last_px, body;

  always_comb begin
    in_act  = (state_i == FLT_ACT);
    lv_o    = in_act && (vc_i < n_s) && (hc_i < a_s);
    last_px = lv_o && (vc_i == n_s - VW'(1)) && (hc_i == a_s - HW'(1));
    body    = in_act && ((vc_i < n_s - VW'(1)) ||
                         ((vc_i == n_s - VW'(1)) && (hc_i < a_s)));
    tr_d    = tr_q;
    if (en) begin
      if (last_px)          tr_d = GW'(GUARD);
      else if (tr_q != '0)  tr_d = tr_q - GW'(1);
    end
    fv_o = (state_i == FLT_LEAD) || body || (tr_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tr_q <= '0;
    else        tr_q <= tr_d;
  end

  // R3: line-valid is contained in frame-valid
  p_lv_inside_fv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lv_o |-> fv_o);

  // R3: frame-valid opens with the line still quiet
  p_fv_rise_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fv_o) |-> !lv_o);

  // R4: frame-valid closes only after a quiet guard
  p_fv_fall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fv_o) |-> (!lv_o && !$past(lv_o)));
endmodule

// File: rtl/frame_line_timer.sv
module frame_line_timer
  import flt_pkg::*;
#(
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int GUARD = 6,
  parameter int DEF_A = 1832,
  parameter int DEF_L = 3694,
  parameter int DEF_N = 2748,
  parameter int DEF_F = 2891
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [HW-1:0] act_width,
  input  logic [HW-1:0] line_len,
  input  logic [VW-1:0] act_rows,
  input  logic [VW-1:0] frame_lines,
  output logic          frame_valid,
  output logic          line_valid,
  output logic          pix_valid,
  output logic [VW-1:0] row_idx,
  output logic [HW-1:0] col_idx,
  output logic          cfg_err
);
  logic [HW-1:0] a_s, l_s, hc;
  logic [VW-1:0] n_s, f_s, vc;
  logic          load, lv, fv;
  flt_state_e    state;

  flt_cfg_shadow #(.HW(HW), .VW(VW), .GUARD(GUARD), .DEF_A(DEF_A),
                   .DEF_L(DEF_L), .DEF_N(DEF_N), .DEF_F(DEF_F)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .a_i(act_width), .l_i(line_len), .n_i(act_rows), .f_i(frame_lines),
    .a_s(a_s), .l_s(l_s), .n_s(n_s), .f_s(f_s), .err_o(cfg_err)
  );

  flt_raster #(.HW(HW), .VW(VW), .GUARD(GUARD)) u_raster (
    .clk(clk), .rst_n(rst_n), .en(pix_en), .l_s(l_s), .f_s(f_s),
    .state_o(state), .hc_o(hc), .vc_o(vc), .load_o(load)
  );

  flt_guard #(.HW(HW), .VW(VW), .GUARD(GUARD)) u_guard (
    .clk(clk), .rst_n(rst_n), .en(pix_en), .state_i(state),
    .hc_i(hc), .vc_i(vc), .a_s(a_s), .n_s(n_s), .lv_o(lv), .fv_o(fv)
  );

  assign frame_valid = fv;
  assign line_valid  = lv;
  assign pix_valid   = lv & pix_en;
  assign row_idx     = lv ? vc : '0;
  assign col_idx     = lv ? hc : '0;
endmodule

// File: tb/test_frame_line_timer.sv
`timescale 1ns/1ps
module test_frame_line_timer;
  localparam int G  = 6;
  localparam int DA = 5, DL = 16, DN = 3, DF = 5;

  logic        clk = 1'b0;
  logic        rst_n, pix_en;
  logic [11:0] act_width, line_len, act_rows, frame_lines;
  logic        frame_valid, line_valid, pix_valid, cfg_err;
  logic [11:0] row_idx, col_idx;

  frame_line_timer #(.HW(12), .VW(12), .GUARD(G), .DEF_A(DA), .DEF_L(DL),
                     .DEF_N(DN), .DEF_F(DF)) i_frame_line_timer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .act_width(act_width),
    .line_len(line_len), .act_rows(act_rows), .frame_lines(frame_lines),
    .frame_valid(frame_valid), .line_valid(line_valid), .pix_valid(pix_valid),
    .row_idx(row_idx), .col_idx(col_idx), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  int    vecs = 0, bad = 0, cyc = 0;
  bit    done = 1'b0;
  string phase = "R1";

  // slot-based reference model
  bit started, merr;
  int t, mA, mL, mN, mF;

  function automatic bit legal(int a, int l, int n, int f);
    return (a >= 1) && (n >= 1) && (l >= a + 1) && (l >= 2 * G) && (f >= n + 1);
  endfunction

  task automatic model_load();
    if (legal(act_width, line_len, act_rows, frame_lines)) begin
      mA = act_width; mL = line_len; mN = act_rows; mF = frame_lines; merr = 1'b0;
    end else begin
      merr = 1'b1;  // R10: keep previous values
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started = 1'b0; t = 0; merr = 1'b0;
      mA = DA; mL = DL; mN = DN; mF = DF;
    end else if (pix_en) begin
      if (!started) begin
        started = 1'b1; t = 0; model_load();
      end else begin
        t = t + 1;
        if (t == mL * mF) begin t = 0; model_load(); end  // R9: sample at frame start
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] at cycle %0d: got %0d expected %0d", req, phase, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int u, lv_e, fv_e, row_e, col_e;
    if (!done) begin
      lv_e = 0; fv_e = 0; row_e = 0; col_e = 0;
      if (started) begin
        u = t - G;
        if (u >= 0 && (u / mL) < mN && (u % mL) < mA) begin
          lv_e = 1; row_e = u / mL; col_e = u % mL;
        end
        fv_e = (t < 2 * G + (mN - 1) * mL + mA) ? 1 : 0;
      end
      chk("R2 line_valid", int'(line_valid), lv_e);
      chk("R3 R4 R5 frame_valid", int'(frame_valid), fv_e);
      chk("R6 pix_valid", int'(pix_valid), (lv_e != 0 && pix_en) ? 1 : 0);
      chk("R7 row_idx", int'(row_idx), row_e);
      chk("R7 col_idx", int'(col_idx), col_e);
      chk("R10 cfg_err", int'(cfg_err), int'(merr));
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog [%s]: got %0d cycles expected under 150000", phase, cyc);
      summary();
    end
  end

  // mode 0: enable low, 1: enable high, 2: irregular enable
  task automatic step(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      pix_en = (mode == 2) ? 1'($urandom_range(0, 1)) : 1'(mode);
    end
  endtask

  task automatic set_cfg(int a, int l, int n, int f);
    act_width = 12'(a); line_len = 12'(l); act_rows = 12'(n); frame_lines = 12'(f);
  endtask

  initial begin
    rst_n = 1'b0; pix_en = 1'b0;
    set_cfg(8, 20, 4, 6);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R1"; step(10, 0);                    // idle after reset
    phase = "R2 R3 R4 R5"; step(360, 1);          // three frames at full rate
    phase = "R6 R8"; step(800, 2);                // stalled slots
    phase = "R9"; step(37, 1);
    set_cfg(12, 24, 3, 5); step(500, 1);          // mid-frame change
    phase = "R10"; set_cfg(12, 12, 3, 5); step(300, 1);   // L = A refused
    set_cfg(8, 24, 3, 3); step(200, 1);           // F = N refused
    phase = "R10 R2"; set_cfg(11, 12, 1, 2); step(300, 2); // minimum legal frame
    step(5, 0);
    summary();
  end
endmodule